// File: doc/BRIEF.md
# Two-Phase Adaptive Mesh Route Selector

This unit computes the next hop for one router of a two-dimensional mesh network-on-chip. A message travels in two legs: first toward an intermediate node chosen at injection, then toward its final destination. The header gives the destination coordinates, a one-bit leg flag and the intermediate node's identifier. The unit works out which leg the message is in. It selects the target node for that leg and derives two candidate output directions toward it, one by moving along X first and one by moving along Y first.

When the two candidates differ, the unit scores each one. The score is the congestion reported by the neighbour on that side plus the measured delay of the link to it, and the cheaper side is taken. The chosen direction and the updated leg flag are registered and appear one cycle after the header is presented. The surrounding router keeps the updated flag in the header for the next hop.

Top module: `mrs_route_sel`

## Requirements
- R1: The updated leg flag is 1 when any of these holds: the router is the intermediate node (identifier = {Y, X}, X in the low bits), the router's X equals the destination X, or the router's Y equals the destination Y.
- R2: With leg flag 0 at the input and none of the R1 conditions true, the updated leg flag is 0.
- R3: A leg flag of 1 at the input gives an updated flag of 1.
- R4: With updated flag 1 the target is the destination; with updated flag 0 the target is the intermediate node.
- R5: Direction codes are 0 Local, 1 North (Y increases), 2 East (X increases), 3 South, 4 West. The X-first candidate moves in X until the X coordinates match and then in Y. The Y-first candidate does the reverse.
- R6: When both candidates name the same port, that port is output and the cost inputs have no effect.
- R7: When the candidates differ, each is scored as congestion plus delay of its port (4-bit fields, port d at bits 4d+3..4d), and the strictly lower score wins.
- R8: When the differing candidates score equally, the X-first candidate is output.
- R9: A header accepted with hdrValid in cycle n gives outValid high in cycle n+1, carrying that header's result; outValid is low after a cycle without hdrValid.
- R10: In a cycle without hdrValid the registered port and leg flag keep their values, whatever the other inputs do.
- R11: During and right after reset, outValid, outPort and outPhase are 0.
- R12: When the target equals the current router, the output port is Local (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header present this cycle |
| curX | input | X_W | X coordinate of this router |
| curY | input | Y_W | Y coordinate of this router |
| dstX | input | X_W | Destination X |
| dstY | input | Y_W | Destination Y |
| hdrPhase | input | 1 | Leg flag carried by the header |
| midId | input | X_W+Y_W | Intermediate node, {Y, X} |
| congIn | input | 5*COST_W | Neighbour congestion per direction code |
| delayIn | input | 5*COST_W | Link delay per direction code |
| outValid | output | 1 | Result valid |
| outPort | output | 3 | Chosen direction code |
| outPhase | output | 1 | Updated leg flag |

## Verification
The assertions check every cycle that the output timing follows hdrValid. They also check that the outputs hold in idle cycles, that the flag is set under each of its conditions and is never set spuriously, that a message at its destination is delivered locally, and that the port code stays legal. Whether the right one of two differing candidates wins, including ties and costs that cannot matter, depends on arithmetic over the cost fields. Only the bench's sweep of a four-by-four mesh shows that, because it compares every combination of router, destination, intermediate node and leg flag against scores computed independently.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int DIR_W     = 3;
  localparam int NUM_PORTS = 5;

  typedef enum logic [DIR_W-1:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  typedef struct packed {
    logic capture;    // load the result registers
    logic validNext;  // result valid next cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/mrs_dor.sv
module mrs_dor
  import mrs_pkg::*;
#(
  parameter int X_W     = 3,
  parameter int Y_W     = 3,
  parameter bit Y_FIRST = 1'b0
) (
  input  logic [X_W-1:0] curX,
  input  logic [Y_W-1:0] curY,
  input  logic [X_W-1:0] tgtX,
  input  logic [Y_W-1:0] tgtY,
  output dir_e           dir
);
  dir_e xStep;
  dir_e yStep;

  always_comb begin
    if (tgtX > curX)      xStep = DIR_EAST;
    else if (tgtX < curX) xStep = DIR_WEST;
    else                  xStep = DIR_LOCAL;
    if (tgtY > curY)      yStep = DIR_NORTH;
    else if (tgtY < curY) yStep = DIR_SOUTH;
    else                  yStep = DIR_LOCAL;
  end

  if (Y_FIRST) begin : g_yFirst
    assign dir = (yStep != DIR_LOCAL) ? yStep : xStep;
  end else begin : g_xFirst
    assign dir = (xStep != DIR_LOCAL) ? xStep : yStep;
  end
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  assign strobe.capture   = hdrValid;
  assign strobe.validNext = hdrValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.validNext;
  end
endmodule

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
#(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int COST_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [X_W-1:0]              curX,
  input  logic [Y_W-1:0]              curY,
  input  logic [X_W-1:0]              dstX,
  input  logic [Y_W-1:0]              dstY,
  input  logic                        hdrPhase,
  input  logic [X_W+Y_W-1:0]          midId,
  input  logic [NUM_PORTS*COST_W-1:0] congIn,
  input  logic [NUM_PORTS*COST_W-1:0] delayIn,
  output dir_e                        portReg,
  output logic                        phaseReg
);
  localparam int SCORE_W = COST_W + 1;
  localparam int SLOTS   = 1 << DIR_W;

  logic [X_W-1:0] midX, tgtX;
  logic [Y_W-1:0] midY, tgtY;
  logic           atMid, alignX, alignY, nextPhase;

  assign midX = midId[X_W-1:0];
  assign midY = midId[X_W +: Y_W];

  // leg decision
  assign atMid     = (midX == curX) && (midY == curY);
  assign alignX    = (dstX == curX);
  assign alignY    = (dstY == curY);
  assign nextPhase = hdrPhase | atMid | alignX | alignY;

  assign tgtX = nextPhase ? dstX : midX;
  assign tgtY = nextPhase ? dstY : midY;

  // two dimension-order candidates
  dir_e candXy, candYx;

  mrs_dor #(.X_W(X_W), .Y_W(Y_W), .Y_FIRST(1'b0)) u_dorXy (
    .curX(curX), .curY(curY), .tgtX(tgtX), .tgtY(tgtY), .dir(candXy)
  );
  mrs_dor #(.X_W(X_W), .Y_W(Y_W), .Y_FIRST(1'b1)) u_dorYx (
    .curX(curX), .curY(curY), .tgtX(tgtX), .tgtY(tgtY), .dir(candYx)
  );

  // per-port cost, padded to every code the direction field can hold
  logic [SCORE_W-1:0] score [SLOTS];
  for (genvar p = 0; p < SLOTS; p++) begin : g_score
    if (p < NUM_PORTS) begin : g_real
      assign score[p] = SCORE_W'(congIn[p*COST_W +: COST_W])
                      + SCORE_W'(delayIn[p*COST_W +: COST_W]);
    end else begin : g_pad
      assign score[p] = '1;
    end
  end

  logic [SCORE_W-1:0] scoreXy, scoreYx;
  logic               sameCand, pickYx;
  dir_e               chosen;

  assign scoreXy  = score[candXy];
  assign scoreYx  = score[candYx];
  assign sameCand = (candXy == candYx);
  assign pickYx   = !sameCand && (scoreYx < scoreXy);
  assign chosen   = pickYx ? candYx : candXy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg  <= DIR_LOCAL;
      phaseReg <= 1'b0;
    end else if (strobe.capture) begin
      portReg  <= chosen;
      phaseReg <= nextPhase;
    end
  end
endmodule

// File: rtl/mrs_route_sel.sv
module mrs_route_sel
  import mrs_pkg::*;
#(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int COST_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hdrValid,
  input  logic [X_W-1:0]              curX,
  input  logic [Y_W-1:0]              curY,
  input  logic [X_W-1:0]              dstX,
  input  logic [Y_W-1:0]              dstY,
  input  logic                        hdrPhase,
  input  logic [X_W+Y_W-1:0]          midId,
  input  logic [NUM_PORTS*COST_W-1:0] congIn,
  input  logic [NUM_PORTS*COST_W-1:0] delayIn,
  output logic                        outValid,
  output logic [DIR_W-1:0]            outPort,
  output logic                        outPhase
);
  ctrlStrobe_t strobe;
  dir_e        portReg;

  mrs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid),
    .strobe(strobe), .outValid(outValid)
  );

  mrs_datapath #(.X_W(X_W), .Y_W(Y_W), .COST_W(COST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .hdrPhase(hdrPhase), .midId(midId),
    .congIn(congIn), .delayIn(delayIn),
    .portReg(portReg), .phaseReg(outPhase)
  );

  assign outPort = portReg;
endmodule

// File: rtl/mrs_route_chk.sv
module mrs_route_chk #(
  parameter int X_W = 3,
  parameter int Y_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               hdrValid,
  input logic [X_W-1:0]     curX,
  input logic [Y_W-1:0]     curY,
  input logic [X_W-1:0]     dstX,
  input logic [Y_W-1:0]     dstY,
  input logic               hdrPhase,
  input logic [X_W+Y_W-1:0] midId,
  input logic               outValid,
  input logic [2:0]         outPort,
  input logic               outPhase
);
  logic anyCond;
  assign anyCond = (curX == dstX) || (curY == dstY) || (midId == {curY, curX});

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> outValid);
  p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !outValid);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> ($stable(outPort) && $stable(outPhase)));
  p_phase_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && anyCond) |=> outPhase);
  p_phase_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !hdrPhase && !anyCond) |=> !outPhase);
  p_phase_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrPhase) |=> outPhase);
  p_local_arrive_r12: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrPhase && curX == dstX && curY == dstY) |=> (outPort == 3'd0));
  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outPort <= 3'd4));
endmodule

bind mrs_route_sel mrs_route_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid),
  .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
  .hdrPhase(hdrPhase), .midId(midId),
  .outValid(outValid), .outPort(outPort), .outPhase(outPhase)
);

// File: tb/mrs_route_sel_tb.sv
`timescale 1ns/1ps
module mrs_route_sel_tb;
  localparam int XW = 2;
  localparam int YW = 2;
  localparam int CW = 4;

  logic           clk = 1'b0;
  logic           rstN;
  logic           hdrValid;
  logic [XW-1:0]  curX, dstX;
  logic [YW-1:0]  curY, dstY;
  logic           hdrPhase;
  logic [XW+YW-1:0] midId;
  logic [5*CW-1:0] congIn, delayIn;
  logic           outValid;
  logic [2:0]     outPort;
  logic           outPhase;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  mrs_route_sel #(.X_W(XW), .Y_W(YW), .COST_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid),
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .hdrPhase(hdrPhase), .midId(midId),
    .congIn(congIn), .delayIn(delayIn),
    .outValid(outValid), .outPort(outPort), .outPhase(outPhase)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int firstX(int cx, int cy, int tx, int ty);
    if (tx > cx) return 2;
    if (tx < cx) return 4;
    if (ty > cy) return 1;
    if (ty < cy) return 3;
    return 0;
  endfunction

  function automatic int firstY(int cx, int cy, int tx, int ty);
    if (ty > cy) return 1;
    if (ty < cy) return 3;
    if (tx > cx) return 2;
    if (tx < cx) return 4;
    return 0;
  endfunction

  function automatic int costOf(int p);
    return int'(congIn[p*4 +: 4]) + int'(delayIn[p*4 +: 4]);
  endfunction

  function automatic logic [31:0] nextRand(logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  int expPort, expPhase;
  string portTag;

  // model: uses the inputs currently driven
  task automatic model();
    int cx = int'(curX), cy = int'(curY), tx, ty, a, b;
    int mx = int'(midId[1:0]), my = int'(midId[3:2]);
    expPhase = (hdrPhase || (cx == int'(dstX)) || (cy == int'(dstY)) ||
                (mx == cx && my == cy)) ? 1 : 0;
    tx = expPhase ? int'(dstX) : mx;
    ty = expPhase ? int'(dstY) : my;
    a = firstX(cx, cy, tx, ty);
    b = firstY(cx, cy, tx, ty);
    if (a == b) begin
      expPort = a;
      portTag = (a == 0) ? "R12 local" : "R6 same candidate";
    end else if (costOf(b) < costOf(a)) begin
      expPort = b;
      portTag = "R7 lower score";
    end else begin
      expPort = a;
      portTag = (costOf(b) == costOf(a)) ? "R8 tie" : "R7 lower score";
    end
  endtask

  task automatic applyAndCheck();
    @(negedge clk);
    hdrValid = 1'b1;
    model();
    @(negedge clk);
    checkVal("R9 outValid", int'(outValid), 1);
    checkVal(portTag, int'(outPort), expPort);
    if (hdrPhase)
      checkVal("R3 phase kept", int'(outPhase), expPhase);
    else if (expPhase == 1)
      checkVal("R1 phase set", int'(outPhase), expPhase);
    else
      checkVal("R2 phase clear", int'(outPhase), expPhase);
  endtask

  initial begin
    rstN = 1'b0; hdrValid = 1'b0; curX = '0; curY = '0; dstX = '0; dstY = '0;
    hdrPhase = 1'b0; midId = '0; congIn = '0; delayIn = '0;
    repeat (3) @(negedge clk);
    checkVal("R11 reset valid", int'(outValid), 0);
    checkVal("R11 reset port", int'(outPort), 0);
    checkVal("R11 reset phase", int'(outPhase), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R11 after reset valid", int'(outValid), 0);

    // R4: leg 0 heads to intermediate, leg 1 to destination
    curX = 2'd1; curY = 2'd1; dstX = 2'd3; dstY = 2'd3; midId = 4'b0000;
    hdrPhase = 1'b0; congIn = '0; delayIn = '0;
    applyAndCheck();
    checkVal("R4 toward intermediate", int'(outPort), 4);
    hdrPhase = 1'b1;
    applyAndCheck();
    checkVal("R4 toward destination", int'(outPort), 2);

    // R7 / R8: East vs North from (0,0) to (2,2)
    curX = 2'd0; curY = 2'd0; dstX = 2'd2; dstY = 2'd2; hdrPhase = 1'b1;
    congIn = 20'h0_0_0_5_0; delayIn = 20'h0_0_0_1_0;   // North 5+1
    congIn[2*4 +: 4] = 4'd3; delayIn[2*4 +: 4] = 4'd4; // East 3+4
    applyAndCheck();
    checkVal("R7 north cheaper", int'(outPort), 1);
    delayIn[2*4 +: 4] = 4'd3;                          // East 6, tie
    applyAndCheck();
    checkVal("R8 tie to X-first", int'(outPort), 2);

    // R6: both candidates East, East very costly
    dstX = 2'd2; dstY = 2'd0;
    congIn = 20'h0_0_F_0_0; delayIn = 20'h0_0_F_0_0;
    applyAndCheck();
    checkVal("R6 cost ignored", int'(outPort), 2);

    // R10: idle cycles keep outputs while inputs move
    @(negedge clk);
    hdrValid = 1'b0; dstX = 2'd0; dstY = 2'd3; hdrPhase = 1'b0; midId = 4'b1111;
    congIn = '1; delayIn = 20'h12345;
    repeat (3) @(negedge clk);
    checkVal("R9 idle valid low", int'(outValid), 0);
    checkVal("R10 port held", int'(outPort), 2);
    checkVal("R10 phase held", int'(outPhase), 1);

    // exhaustive sweep of a 4x4 mesh (R1..R8, R12)
    for (int cy = 0; cy < 4; cy++)
      for (int cx = 0; cx < 4; cx++)
        for (int dy = 0; dy < 4; dy++)
          for (int dx = 0; dx < 4; dx++)
            for (int mi = 0; mi < 16; mi++)
              for (int ph = 0; ph < 2; ph++) begin
                seed = nextRand(seed);
                congIn = seed[19:0];
                seed = nextRand(seed);
                delayIn = seed[19:0];
                if (seed[31]) begin
                  congIn  = congIn & 20'h33333;
                  delayIn = delayIn & 20'h11111;
                end
                curX = 2'(cx); curY = 2'(cy); dstX = 2'(dx); dstY = 2'(dy);
                midId = 4'(mi); hdrPhase = ph[0];
                applyAndCheck();
              end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule